// File: doc/BRIEF.md
# Cache Stall Cause Tracker

This block decides when the CPU-facing request path of a cache must be held off, and records why. It holds a small mask with one bit per stall cause. Cause 0 means the miss queue is full, cause 1 means the write-back queue is full, and cause 2 means no target slot is free. The stall output is high while any bit of the mask is set. Causes are raised and dropped in two ways. The surrounding cache logic can pulse them directly. The block can also derive them from allocation and issue events on the two queues, together with each queue's full level.

For every cause the block keeps two saturating counters. The first counts stall episodes, where an episode runs from the moment the mask leaves zero until it returns to zero. The second sums the cycles spent inside those episodes. An episode's count is charged to the cause that opened it. Its cycle total is charged to the cause whose removal closed it. A free-running cycle counter provides the timestamps.

Top module: `cache_stall_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, the mask, the stall output and all episode and cycle counters become zero.
- R2: A set pulse on cause c (bit c of a cause vector: 0 miss queue, 1 write-back queue, 2 no targets) makes bit c of `cause_mask_o` high from the following cycle on, and leaves the other bits as they were.
- R3: A clear pulse on cause c drops only bit c. Clearing a cause whose bit is already low changes neither the mask nor any counter.
- R4: When set and clear for the same cause arrive in the same cycle, the set takes effect.
- R5: When the mask is zero and one or more causes are set, the episode counter of the lowest-numbered cause being set goes up by one.
- R6: Setting a cause while the mask is already nonzero changes only the mask. No episode counter moves.
- R7: When the mask returns to zero, the number of cycles the stall output was high during that episode is added to the cycle counter of the lowest-numbered cause removed in the closing cycle.
- R8: An allocation on queue q (bit 0 miss queue, bit 1 write-back queue) in a cycle where that queue's full input is high sets cause q.
- R9: An issue on queue q clears cause q only when that queue's full input was high in the previous cycle and is low in the current one.
- R10: Episode and cycle counters saturate at their maximum value and never wrap.
- R11: `stall_o` is high exactly when `cause_mask_o` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cause_set_i | input | NUM_CAUSES | Per-cause set pulses |
| cause_clr_i | input | NUM_CAUSES | Per-cause clear pulses |
| q_full_i | input | NUM_QUEUES | Queue full levels, reflecting the state after this cycle's events |
| q_alloc_i | input | NUM_QUEUES | Queue allocation events |
| q_issue_i | input | NUM_QUEUES | Queue entry issued (marked in service) events |
| stall_o | output | 1 | Registered stall toward the CPU-side port |
| cause_mask_o | output | NUM_CAUSES | Registered stall cause mask |
| episode_cnt_o | output | NUM_CAUSES*CNT_W | Episode counters, cause c at bits [c*CNT_W +: CNT_W] |
| stall_cycles_o | output | NUM_CAUSES*CNT_W | Stalled-cycle totals, cause c at bits [c*CNT_W +: CNT_W] |

## Verification
The property that new mask bits appear only after a set assumes that no bit can rise except through a set pulse or an allocation into a full queue. The stimulus drives only those inputs to raise causes. The monotonic-counter properties assume that reset is held long enough for every counter to load zero, and the bench keeps reset high for several cycles. Random stimulus keeps pulses sparse, so episodes of different lengths occur, overlap, and sometimes see a set and a clear in the same cycle. Full levels are toggled independently of allocations, which exercises issue events both with and without a preceding full cycle.

// File: rtl/stall_pkg.sv
`timescale 1ns/1ps
package stall_pkg;
  typedef enum logic [1:0] {
    CAUSE_MISSQ = 2'd0,
    CAUSE_WBUF  = 2'd1,
    CAUSE_NOTGT = 2'd2
  } stall_cause_e;

  localparam int CAUSE_COUNT = 3;
  localparam int QUEUE_COUNT = int'(CAUSE_WBUF) + 1;
endpackage

// File: rtl/stall_queue_events.sv
`timescale 1ns/1ps
module stall_queue_events #(
  parameter int NUM_CAUSES = 3,
  parameter int NUM_QUEUES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_QUEUES-1:0] q_full,
  input  logic [NUM_QUEUES-1:0] q_alloc,
  input  logic [NUM_QUEUES-1:0] q_issue,
  output logic [NUM_CAUSES-1:0] q_set,
  output logic [NUM_CAUSES-1:0] q_clr
);
  logic [NUM_QUEUES-1:0] full_prev;

  always_ff @(posedge clk) begin
    if (rst) full_prev <= '0;
    else     full_prev <= q_full;
  end

  for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_map
    if (c < NUM_QUEUES) begin : g_queue
      assign q_set[c] = q_alloc[c] & q_full[c];
      assign q_clr[c] = q_issue[c] & full_prev[c] & ~q_full[c];
    end else begin : g_none
      assign q_set[c] = 1'b0;
      assign q_clr[c] = 1'b0;
    end
  end
endmodule

// File: rtl/stall_mask_ctrl.sv
`timescale 1ns/1ps
module stall_mask_ctrl #(
  parameter int NUM_CAUSES = 3,
  parameter int TIME_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CAUSES-1:0] set_v,
  input  logic [NUM_CAUSES-1:0] clr_v,
  output logic [NUM_CAUSES-1:0] mask_q,
  output logic                  stall_q,
  output logic [NUM_CAUSES-1:0] open_hit,
  output logic [NUM_CAUSES-1:0] close_hit,
  output logic [TIME_W-1:0]     close_delta
);
  localparam logic [NUM_CAUSES-1:0] ONE = NUM_CAUSES'(1);

  logic [NUM_CAUSES-1:0] mask_nx;
  logic [NUM_CAUSES-1:0] removed;
  logic                  opening;
  logic                  closing;
  logic [TIME_W-1:0]     cyc_q;
  logic [TIME_W-1:0]     start_q;

  always_comb begin
    mask_nx     = (mask_q & ~clr_v) | set_v;
    removed     = mask_q & clr_v;
    opening     = (mask_q == '0) && (set_v != '0);
    closing     = (mask_q != '0) && (mask_nx == '0);
    open_hit    = opening ? (set_v & (~set_v + ONE)) : '0;
    close_hit   = closing ? (removed & (~removed + ONE)) : '0;
    close_delta = cyc_q - start_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      stall_q <= 1'b0;
      cyc_q   <= '0;
      start_q <= '0;
    end else begin
      mask_q  <= mask_nx;
      stall_q <= (mask_nx != '0);
      cyc_q   <= cyc_q + TIME_W'(1);
      if (opening) start_q <= cyc_q;
    end
  end
endmodule

// File: rtl/stall_stat_bank.sv
`timescale 1ns/1ps
module stall_stat_bank #(
  parameter int NUM_CAUSES = 3,
  parameter int CNT_W      = 32,
  parameter int TIME_W     = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CAUSES-1:0]       open_hit,
  input  logic [NUM_CAUSES-1:0]       close_hit,
  input  logic [TIME_W-1:0]           close_delta,
  output logic [NUM_CAUSES*CNT_W-1:0] episodes,
  output logic [NUM_CAUSES*CNT_W-1:0] cycles
);
  localparam int SUM_W = ((CNT_W > TIME_W) ? CNT_W : TIME_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [SUM_W-1:0] SUM_LIM = SUM_W'(CNT_MAX);

  for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_cause
    logic [CNT_W-1:0] ep_q;
    logic [CNT_W-1:0] acc_q;
    logic [SUM_W-1:0] sum;

    assign sum = SUM_W'(acc_q) + SUM_W'(close_delta);

    always_ff @(posedge clk) begin
      if (rst) begin
        ep_q  <= '0;
        acc_q <= '0;
      end else begin
        if (open_hit[c] && (ep_q != CNT_MAX)) ep_q <= ep_q + CNT_W'(1);
        if (close_hit[c]) begin
          if (sum > SUM_LIM) acc_q <= CNT_MAX;
          else               acc_q <= sum[CNT_W-1:0];
        end
      end
    end

    assign episodes[c*CNT_W +: CNT_W] = ep_q;
    assign cycles[c*CNT_W +: CNT_W]   = acc_q;
  end
endmodule

// File: rtl/cache_stall_tracker.sv
`timescale 1ns/1ps
module cache_stall_tracker #(
  parameter int NUM_CAUSES = stall_pkg::CAUSE_COUNT,
  parameter int NUM_QUEUES = stall_pkg::QUEUE_COUNT,
  parameter int CNT_W      = 32,
  parameter int TIME_W     = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CAUSES-1:0]       cause_set_i,
  input  logic [NUM_CAUSES-1:0]       cause_clr_i,
  input  logic [NUM_QUEUES-1:0]       q_full_i,
  input  logic [NUM_QUEUES-1:0]       q_alloc_i,
  input  logic [NUM_QUEUES-1:0]       q_issue_i,
  output logic                        stall_o,
  output logic [NUM_CAUSES-1:0]       cause_mask_o,
  output logic [NUM_CAUSES*CNT_W-1:0] episode_cnt_o,
  output logic [NUM_CAUSES*CNT_W-1:0] stall_cycles_o
);
  logic [NUM_CAUSES-1:0] q_set, q_clr;
  logic [NUM_CAUSES-1:0] set_v, clr_v;
  logic [NUM_CAUSES-1:0] open_hit, close_hit;
  logic [TIME_W-1:0]     close_delta;

  stall_queue_events #(
    .NUM_CAUSES(NUM_CAUSES), .NUM_QUEUES(NUM_QUEUES)
  ) u_qev (
    .clk(clk), .rst(rst),
    .q_full(q_full_i), .q_alloc(q_alloc_i), .q_issue(q_issue_i),
    .q_set(q_set), .q_clr(q_clr)
  );

  assign set_v = cause_set_i | q_set;
  assign clr_v = cause_clr_i | q_clr;

  stall_mask_ctrl #(
    .NUM_CAUSES(NUM_CAUSES), .TIME_W(TIME_W)
  ) u_mask (
    .clk(clk), .rst(rst),
    .set_v(set_v), .clr_v(clr_v),
    .mask_q(cause_mask_o), .stall_q(stall_o),
    .open_hit(open_hit), .close_hit(close_hit),
    .close_delta(close_delta)
  );

  stall_stat_bank #(
    .NUM_CAUSES(NUM_CAUSES), .CNT_W(CNT_W), .TIME_W(TIME_W)
  ) u_stats (
    .clk(clk), .rst(rst),
    .open_hit(open_hit), .close_hit(close_hit),
    .close_delta(close_delta),
    .episodes(episode_cnt_o), .cycles(stall_cycles_o)
  );
endmodule

// File: rtl/cache_stall_tracker_chk.sv
`timescale 1ns/1ps
module cache_stall_tracker_chk #(
  parameter int NUM_CAUSES = 3,
  parameter int NUM_QUEUES = 2,
  parameter int CNT_W      = 32
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_CAUSES-1:0]       cause_set_i,
  input logic [NUM_QUEUES-1:0]       q_full_i,
  input logic [NUM_QUEUES-1:0]       q_alloc_i,
  input logic                        stall_o,
  input logic [NUM_CAUSES-1:0]       cause_mask_o,
  input logic [NUM_CAUSES*CNT_W-1:0] episode_cnt_o,
  input logic [NUM_CAUSES*CNT_W-1:0] stall_cycles_o
);
  logic [NUM_QUEUES-1:0] q_raise;
  assign q_raise = q_alloc_i & q_full_i;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cause_mask_o == '0 && !stall_o));

  a_r11_stall_tracks_mask: assert property (@(posedge clk) disable iff (rst)
    stall_o == (cause_mask_o != '0));

  a_r3_no_new_bits_without_set: assert property (@(posedge clk) disable iff (rst)
    (cause_set_i == '0 && q_raise == '0) |=> ((cause_mask_o & ~$past(cause_mask_o)) == '0));

  a_r6_no_episode_while_stalled: assert property (@(posedge clk) disable iff (rst)
    (cause_mask_o != '0) |=> $stable(episode_cnt_o));

  a_r7_cycles_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (cause_mask_o == '0) |=> $stable(stall_cycles_o));

  a_r7_cycles_only_on_close: assert property (@(posedge clk) disable iff (rst)
    (cause_mask_o != '0) |=> (cause_mask_o == '0 || $stable(stall_cycles_o)));

  for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_c
    a_r4_set_takes_effect: assert property (@(posedge clk) disable iff (rst)
      cause_set_i[c] |=> cause_mask_o[c]);

    a_r10_episodes_no_wrap: assert property (@(posedge clk) disable iff (rst)
      episode_cnt_o[c*CNT_W +: CNT_W] >= $past(episode_cnt_o[c*CNT_W +: CNT_W]));

    a_r10_cycles_no_wrap: assert property (@(posedge clk) disable iff (rst)
      stall_cycles_o[c*CNT_W +: CNT_W] >= $past(stall_cycles_o[c*CNT_W +: CNT_W]));
  end
endmodule

bind cache_stall_tracker cache_stall_tracker_chk #(
  .NUM_CAUSES(NUM_CAUSES), .NUM_QUEUES(NUM_QUEUES), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .cause_set_i(cause_set_i),
  .q_full_i(q_full_i), .q_alloc_i(q_alloc_i),
  .stall_o(stall_o), .cause_mask_o(cause_mask_o),
  .episode_cnt_o(episode_cnt_o), .stall_cycles_o(stall_cycles_o)
);

// File: tb/cache_stall_tracker_tb.sv
`timescale 1ns/1ps
module cache_stall_tracker_tb_top;
  localparam int NC = 3;
  localparam int NQ = 2;
  localparam int CW = 8;
  localparam int TW = 32;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0] cause_set = '0, cause_clr = '0;
  logic [NQ-1:0] q_full = '0, q_alloc = '0, q_issue = '0;
  logic stall;
  logic [NC-1:0] mask;
  logic [NC*CW-1:0] eps, cyc;

  always #4 clk = ~clk;

  cache_stall_tracker #(.NUM_CAUSES(NC), .NUM_QUEUES(NQ), .CNT_W(CW), .TIME_W(TW)) dut_i (
    .clk(clk), .rst(rst), .cause_set_i(cause_set), .cause_clr_i(cause_clr),
    .q_full_i(q_full), .q_alloc_i(q_alloc), .q_issue_i(q_issue),
    .stall_o(stall), .cause_mask_o(mask),
    .episode_cnt_o(eps), .stall_cycles_o(cyc)
  );

  int n_checks = 0, n_fail = 0;
  string cur_req = "R1";

  logic [NC-1:0] m_mask;
  logic [NQ-1:0] m_prev;
  longint m_cyc, m_start;
  int m_ep [NC];
  int m_acc [NC];

  function automatic int lowest(input logic [NC-1:0] v);
    for (int i = 0; i < NC; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic model_tick();
    logic [NC-1:0] s, cl, nx;
    int k;
    if (rst) begin
      m_mask = '0; m_prev = '0; m_cyc = 0; m_start = 0;
      for (int i = 0; i < NC; i++) begin m_ep[i] = 0; m_acc[i] = 0; end
      return;
    end
    s = cause_set; cl = cause_clr;
    for (int q = 0; q < NQ; q++) begin
      if (q_alloc[q] && q_full[q]) s[q] = 1'b1;
      if (q_issue[q] && m_prev[q] && !q_full[q]) cl[q] = 1'b1;
    end
    nx = (m_mask & ~cl) | s;
    if (m_mask == '0 && s != '0) begin
      k = lowest(s);
      if (m_ep[k] < CMAX) m_ep[k]++;
      m_start = m_cyc;
    end
    if (m_mask != '0 && nx == '0) begin
      longint t;
      k = lowest(m_mask & cl);
      t = longint'(m_acc[k]) + (m_cyc - m_start);
      m_acc[k] = (t > CMAX) ? CMAX : int'(t);
    end
    m_mask = nx; m_prev = q_full; m_cyc++;
  endtask

  task automatic chk(input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("mask", longint'(mask), longint'(m_mask));
    chk("stall", longint'(stall), longint'(m_mask != '0));
    for (int i = 0; i < NC; i++) begin
      chk($sformatf("episodes[%0d]", i), longint'(eps[i*CW +: CW]), longint'(m_ep[i]));
      chk($sformatf("cycles[%0d]", i), longint'(cyc[i*CW +: CW]), longint'(m_acc[i]));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_tick();
    @(negedge clk);
    compare();
    cause_set = '0; cause_clr = '0; q_alloc = '0; q_issue = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c5e));
    @(negedge clk);
    cur_req = "R1"; ticks(3);
    rst = 1'b0;
    // R2: single cause set, mask bit 1 (write-back queue)
    cur_req = "R2"; cause_set = 3'b010; tick(); ticks(3);
    // R3: clear only drops its bit; episode closes, 4 cycles to cause 1
    cur_req = "R3"; cause_clr = 3'b010; tick();
    cause_clr = 3'b100; tick();          // R3: clearing inactive bit no effect
    // R6 / R7: cause 0 opens, cause 2 joins, close via cause 2
    cur_req = "R6"; cause_set = 3'b001; tick(); ticks(2);
    cause_set = 3'b100; tick(); ticks(2);
    cur_req = "R7"; cause_clr = 3'b001; tick(); ticks(2);
    cause_clr = 3'b100; tick(); tick();
    // R4: set and clear same cause same cycle
    cur_req = "R4"; cause_set = 3'b100; cause_clr = 3'b100; tick(); ticks(1);
    cause_clr = 3'b100; tick();
    // R5: two causes open together, lowest charged
    cur_req = "R5"; cause_set = 3'b110; tick();
    cause_clr = 3'b110; tick(); tick();
    // R8: allocation into a full miss queue
    cur_req = "R8"; q_full = 2'b01; q_alloc = 2'b01; tick();
    q_alloc = 2'b10; tick();             // R8: write-back alloc while not full
    // R9: issue while queue stays full, then issue that drops full
    cur_req = "R9"; q_issue = 2'b01; tick();
    q_full = 2'b00; q_issue = 2'b01; tick(); tick();
    // R9: issue without previous full leaves bit
    cause_set = 3'b010; tick();
    q_issue = 2'b10; tick();
    q_full = 2'b10; tick();
    q_full = 2'b00; q_issue = 2'b10; tick(); tick();
    // R10: saturate episode counter of cause 0
    cur_req = "R10";
    for (int i = 0; i < 300; i++) begin
      cause_set = 3'b001; tick();
      cause_clr = 3'b001; tick();
    end
    cause_set = 3'b100; tick(); ticks(300);
    cause_clr = 3'b100; tick(); tick();
    // R11: random mix
    cur_req = "R11";
    for (int i = 0; i < 3000; i++) begin
      for (int c = 0; c < NC; c++) begin
        cause_set[c] = ($urandom % 10) == 0;
        cause_clr[c] = ($urandom % 6) == 0;
      end
      for (int q = 0; q < NQ; q++) begin
        if (($urandom % 8) == 0) q_full[q] = ~q_full[q];
        q_alloc[q] = ($urandom % 4) == 0;
        q_issue[q] = ($urandom % 4) == 0;
      end
      tick();
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule